// File: doc/BRIEF.md
# Shared-Bus Multicycle 16-bit Processor

A compact 16-bit processor whose datapath units (program counter, instruction register, memory address and data registers, an eight-entry register file, an ALU, an address adder and three condition flags) exchange values over a single 16-bit internal bus. In any cycle at most one unit places its value on that bus, and any set of registers may capture it. A control state machine steps every instruction through a fixed sequence: fetch, decode, address evaluation, operand access, execute and write-back. In each state it decides which unit drives the bus, which registers load and what the ALU does.

The block talks to a word-addressed synchronous memory through one port: an address, write data, read data and separate read and write strobes. Read data must appear on `mem_rdata` in the cycle after the read strobe. The supported operations are register/immediate add, bitwise AND, bitwise NOT, base-plus-offset load and store, and a flag-conditioned PC-relative branch. Every other opcode passes through as a no-op.

Top module: `shbus_cpu`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, the PC is cleared to 0x0000, the flags become Z only (N=0, Z=1, P=0) and both memory strobes are low. The first read after reset goes to address 0x0000.
- R2: Fetch places the PC in the memory address register and increments the PC. It then asserts a one-cycle read strobe and moves the returned word through the data register into the instruction register, so instructions are fetched from consecutive addresses unless a branch is taken. Read and write strobes are never asserted together, and neither stays high for two consecutive cycles.
- R3: At most one source drives the internal bus in any cycle. The instruction register, PC and flags change only in cycles where the controller enables their load.
- R4: Opcode IR[15:12]=0001 adds and 0101 ANDs. The destination is IR[11:9] and the first source is IR[8:6]. If IR[5]=1 the second operand is the sign-extended IR[4:0]; otherwise it is the register named by IR[2:0]. Opcode 1001 writes the bitwise complement of register IR[8:6] into IR[11:9], with IR[5:0]=111111.
- R5: Opcode 0110 loads and 0111 stores one word at the address formed by register IR[8:6] plus the sign-extended IR[5:0]. A load writes register IR[11:9]. A store writes register IR[11:9] to memory: the value is placed in the data register first, and the write strobe is asserted for one cycle in a later state.
- R6: Opcode 0000 branches. IR[11], IR[10] and IR[9] select the N, Z and P flags respectively. The branch is taken when any selected flag is set, and the target is the already incremented PC plus the sign-extended IR[8:0]. A mask of 000 never branches.
- R7: Add, AND, NOT and load set the flags from the value they write back: N if bit 15 is 1, Z if the value is all zeros, P otherwise. Exactly one flag is set at all times. Stores, branches and no-ops leave the flags unchanged.
- R8: Any opcode other than 0000, 0001, 0101, 0110, 0111 and 1001 returns to fetch without writing a register, a flag or memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address for memory reads and writes |
| mem_wdata | output | 16 | Data for a memory write |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The bound checker watches every cycle for the structural rules: a single bus driver, read and write strobes that are short and mutually exclusive, a flag register that is always one-hot, and instruction register, PC and flags that hold whenever their load enable is low. What an instruction computes can only be seen at the memory port, so the bench runs a program whose stores expose each ALU result, each load result and each effective address, including a negative offset. Flag behaviour, the reset value of the flags, no-op handling and taken or untaken branches are shown by which stores appear and in what order, and by the addresses of the first fetches after reset.

// File: rtl/shbus_pkg.sv
// Package shbus_pkg
// Shared types and encodings for the shared-bus processor: bus source
// indices, opcode values, controller states, datapath mux selects and the
// bundle of control lines the controller drives each cycle.
// Assumes a 4-bit opcode field at IR[15:12].
package shbus_pkg;

    // Number of units that can drive the internal bus, and their indices.
    localparam int BUS_N      = 4;
    localparam int BUS_PC     = 0;
    localparam int BUS_MDR    = 1;
    localparam int BUS_ALU    = 2;
    localparam int BUS_MARMUX = 3;

    // Opcode values in IR[15:12].
    localparam logic [3:0] OP_BR  = 4'h0;
    localparam logic [3:0] OP_ADD = 4'h1;
    localparam logic [3:0] OP_AND = 4'h5;
    localparam logic [3:0] OP_LDR = 4'h6;
    localparam logic [3:0] OP_STR = 4'h7;
    localparam logic [3:0] OP_NOT = 4'h9;

    typedef enum logic [3:0] {
        S_F1,       // PC onto bus, load MAR, increment PC
        S_F2,       // read strobe
        S_F3,       // memory word into MDR
        S_F4,       // MDR onto bus, load IR
        S_DEC,      // opcode decode
        S_BR,       // branch target evaluation
        S_EA,       // load/store address evaluation
        S_LD_RD,    // load: read strobe
        S_LD_MDR,   // load: memory word into MDR
        S_LD_WB,    // load: MDR to register and flags
        S_SW_MDR,   // store: source register into MDR
        S_SW_WR,    // store: write strobe
        S_EXE       // ALU operation and write-back
    } state_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_e;
    typedef enum logic [1:0] {PC_INC, PC_ADDER, PC_BUS} pc_sel_e;
    typedef enum logic {MAR_ZEXT, MAR_ADDER} mar_sel_e;
    typedef enum logic {MDR_MEM, MDR_BUS} mdr_sel_e;
    typedef enum logic {A1_PC, A1_BASE} a1_sel_e;
    typedef enum logic {A2_OFF6, A2_OFF9} a2_sel_e;
    typedef enum logic {SR1_BASE, SR1_DST} sr1_sel_e;

    // Control lines produced by the controller in every state.
    typedef struct packed {
        logic [BUS_N-1:0] bus_en;
        logic             ld_mar;
        logic             ld_mdr;
        logic             ld_ir;
        logic             ld_pc;
        logic             ld_reg;
        logic             ld_cc;
        logic             mem_rd;
        logic             mem_wr;
        pc_sel_e          pc_sel;
        mar_sel_e         mar_sel;
        mdr_sel_e         mdr_sel;
        a1_sel_e          a1_sel;
        a2_sel_e          a2_sel;
        sr1_sel_e         sr1_sel;
        alu_op_e          alu_op;
    } ctl_t;

endpackage

// File: rtl/shbus_regfile.sv
// Module shbus_regfile
// General-purpose register file: NREG words of DW bits, two combinational
// read ports and one synchronous write port. The contents are not reset;
// software must write a register before it reads it.
module shbus_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs [NREG];

    // Write port: capture write data into the addressed register.
    always_ff @(posedge clk) begin
        if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/shbus_alu.sv
// Module shbus_alu
// Combinational ALU: add, bitwise AND, bitwise NOT of the first operand,
// and pass-through of the first operand (the path store data takes).
// Assumes two's-complement wrap-around; no carry or overflow output.
module shbus_alu import shbus_pkg::*; #(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    // Operation select.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/shbus_ctrl.sv
// Module shbus_ctrl
// Control state machine. It walks each instruction through fetch, decode,
// address evaluation, operand access, execute and write-back, and drives
// one bus source plus the register loads of each state. The opcode passes
// through a full one-hot decoder; opcodes with no meaning return to fetch.
// Assumes the memory returns read data one cycle after the read strobe.
module shbus_ctrl import shbus_pkg::*; #(
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    input  logic [2:0]     br_mask,
    input  logic [2:0]     flags,
    output ctl_t           ctl
);

    localparam int NDEC = 1 << OPW;
    localparam logic [NDEC-1:0] KNOWN = NDEC'((1 << OP_BR) | (1 << OP_ADD) |
                                              (1 << OP_AND) | (1 << OP_LDR) |
                                              (1 << OP_STR) | (1 << OP_NOT));

    logic [NDEC-1:0] dec;
    logic            unknown;
    logic            br_take;
    state_e          st, st_nx;

    // One-hot opcode decoder.
    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        assign dec[g] = (opcode == OPW'(g));
    end

    assign unknown = |(dec & ~KNOWN);
    assign br_take = |(br_mask & flags);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_F1;
        end else begin
            st <= st_nx;
        end
    end

    // Per-state control lines and next state.
    always_comb begin
        ctl   = '0;
        st_nx = st;
        case (st)
            S_F1: begin
                ctl.bus_en[BUS_PC] = 1'b1;
                ctl.ld_mar         = 1'b1;
                ctl.ld_pc          = 1'b1;
                ctl.pc_sel         = PC_INC;
                st_nx              = S_F2;
            end
            S_F2: begin
                ctl.mem_rd = 1'b1;
                st_nx      = S_F3;
            end
            S_F3: begin
                ctl.ld_mdr  = 1'b1;
                ctl.mdr_sel = MDR_MEM;
                st_nx       = S_F4;
            end
            S_F4: begin
                ctl.bus_en[BUS_MDR] = 1'b1;
                ctl.ld_ir           = 1'b1;
                st_nx               = S_DEC;
            end
            S_DEC: begin
                if (unknown) begin
                    st_nx = S_F1;
                end else if (dec[OP_ADD] || dec[OP_AND] || dec[OP_NOT]) begin
                    st_nx = S_EXE;
                end else if (dec[OP_LDR] || dec[OP_STR]) begin
                    st_nx = S_EA;
                end else begin
                    st_nx = S_BR;
                end
            end
            S_BR: begin
                ctl.a1_sel = A1_PC;
                ctl.a2_sel = A2_OFF9;
                ctl.pc_sel = PC_ADDER;
                ctl.ld_pc  = br_take;
                st_nx      = S_F1;
            end
            S_EA: begin
                ctl.sr1_sel            = SR1_BASE;
                ctl.a1_sel             = A1_BASE;
                ctl.a2_sel             = A2_OFF6;
                ctl.mar_sel            = MAR_ADDER;
                ctl.bus_en[BUS_MARMUX] = 1'b1;
                ctl.ld_mar             = 1'b1;
                st_nx                  = dec[OP_LDR] ? S_LD_RD : S_SW_MDR;
            end
            S_LD_RD: begin
                ctl.mem_rd = 1'b1;
                st_nx      = S_LD_MDR;
            end
            S_LD_MDR: begin
                ctl.ld_mdr  = 1'b1;
                ctl.mdr_sel = MDR_MEM;
                st_nx       = S_LD_WB;
            end
            S_LD_WB: begin
                ctl.bus_en[BUS_MDR] = 1'b1;
                ctl.ld_reg          = 1'b1;
                ctl.ld_cc           = 1'b1;
                st_nx               = S_F1;
            end
            S_SW_MDR: begin
                ctl.sr1_sel         = SR1_DST;
                ctl.alu_op          = ALU_PASS;
                ctl.bus_en[BUS_ALU] = 1'b1;
                ctl.ld_mdr          = 1'b1;
                ctl.mdr_sel         = MDR_BUS;
                st_nx               = S_SW_WR;
            end
            S_SW_WR: begin
                ctl.mem_wr = 1'b1;
                st_nx      = S_F1;
            end
            S_EXE: begin
                ctl.sr1_sel         = SR1_BASE;
                ctl.alu_op          = dec[OP_ADD] ? ALU_ADD :
                                      dec[OP_AND] ? ALU_AND : ALU_NOT;
                ctl.bus_en[BUS_ALU] = 1'b1;
                ctl.ld_reg          = 1'b1;
                ctl.ld_cc           = 1'b1;
                st_nx               = S_F1;
            end
            default: st_nx = S_F1;
        endcase
    end

endmodule

// File: rtl/shbus_cpu.sv
// Module shbus_cpu (top)
// Datapath of the shared-bus processor: PC, IR, MAR, MDR, flags, register
// file, ALU and address adder, joined by one internal bus that exactly one
// selected source drives (a one-hot AND-OR network in place of tri-state
// buffers). Memory is word-addressed and synchronous with one cycle of read
// latency. Instruction fields assume DW = 16.
module shbus_cpu import shbus_pkg::*; #(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr
);

    localparam int RA_W = $clog2(NREG);
    localparam logic [2:0] CC_RESET = 3'b010;

    ctl_t            ctl;
    logic [DW-1:0]   pc, ir, mar, mdr;
    logic [2:0]      cc, cc_nx;
    logic [DW-1:0]   bus;
    logic [DW-1:0]   rd_a, rd_b, alu_b, alu_y;
    logic [DW-1:0]   imm5, off6, off9, zext8;
    logic [DW-1:0]   addr1, addr2, adder, marmux, pc_nx, mdr_nx;
    logic [RA_W-1:0] ra_a, ra_b, wa;
    logic [DW-1:0]   bus_src  [BUS_N];
    logic [DW-1:0]   bus_term [BUS_N];

    // Immediate and offset fields.
    assign imm5  = {{(DW-5){ir[4]}}, ir[4:0]};
    assign off6  = {{(DW-6){ir[5]}}, ir[5:0]};
    assign off9  = {{(DW-9){ir[8]}}, ir[8:0]};
    assign zext8 = {{(DW-8){1'b0}}, ir[7:0]};

    // Register file addressing.
    assign ra_a = (ctl.sr1_sel == SR1_DST) ? RA_W'(ir[11:9]) : RA_W'(ir[8:6]);
    assign ra_b = RA_W'(ir[2:0]);
    assign wa   = RA_W'(ir[11:9]);

    shbus_regfile #(.DW(DW), .NREG(NREG), .AW(RA_W)) rf_i (
        .clk  (clk),
        .ra_a (ra_a),
        .ra_b (ra_b),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .we   (ctl.ld_reg),
        .wa   (wa),
        .wd   (bus)
    );

    assign alu_b = ir[5] ? imm5 : rd_b;

    shbus_alu #(.DW(DW)) alu_i (
        .op (ctl.alu_op),
        .a  (rd_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    shbus_ctrl #(.OPW(4)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (ir[15:12]),
        .br_mask (ir[11:9]),
        .flags   (cc),
        .ctl     (ctl)
    );

    // Address adder and the MAR source mux.
    assign addr1  = (ctl.a1_sel == A1_BASE) ? rd_a : pc;
    assign addr2  = (ctl.a2_sel == A2_OFF9) ? off9 : off6;
    assign adder  = addr1 + addr2;
    assign marmux = (ctl.mar_sel == MAR_ZEXT) ? zext8 : adder;

    // Bus sources gated by their one-hot enables, then merged.
    assign bus_src[BUS_PC]     = pc;
    assign bus_src[BUS_MDR]    = mdr;
    assign bus_src[BUS_ALU]    = alu_y;
    assign bus_src[BUS_MARMUX] = marmux;

    for (genvar g = 0; g < BUS_N; g++) begin : g_bus
        assign bus_term[g] = bus_src[g] & {DW{ctl.bus_en[g]}};
    end

    // Merge of the gated bus drivers.
    always_comb begin
        bus = '0;
        for (int i = 0; i < BUS_N; i++) begin
            bus = bus | bus_term[i];
        end
    end

    // PC source mux.
    always_comb begin
        case (ctl.pc_sel)
            PC_ADDER: pc_nx = adder;
            PC_BUS:   pc_nx = bus;
            default:  pc_nx = pc + DW'(1);
        endcase
    end

    assign mdr_nx = (ctl.mdr_sel == MDR_BUS) ? bus : mem_rdata;

    // Flags from the bus value: {N, Z, P}.
    assign cc_nx = {bus[DW-1], (bus == '0), (!bus[DW-1] && (bus != '0))};

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (ctl.ld_pc) begin
            pc <= pc_nx;
        end
    end

    // Instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir <= '0;
        end else if (ctl.ld_ir) begin
            ir <= bus;
        end
    end

    // Memory address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (ctl.ld_mar) begin
            mar <= bus;
        end
    end

    // Memory data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr <= '0;
        end else if (ctl.ld_mdr) begin
            mdr <= mdr_nx;
        end
    end

    // Condition flags register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc <= CC_RESET;
        end else if (ctl.ld_cc) begin
            cc <= cc_nx;
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/shbus_cpu_chk.sv
// Module shbus_cpu_chk
// Cycle-level protocol checker bound into shbus_cpu. It watches the bus
// enables, memory strobes and the load enables of IR, PC and flags.
module shbus_cpu_chk #(
    parameter int NSRC = 4,
    parameter int DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [NSRC-1:0] bus_en,
    input logic            ld_ir,
    input logic [DW-1:0]   ir,
    input logic            ld_pc,
    input logic [DW-1:0]   pc,
    input logic            ld_cc,
    input logic [2:0]      cc
);

    // R3: a single bus driver per cycle
    a_r3_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_en));

    // R3: IR holds without its load enable
    a_r3_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ir |=> $stable(ir));

    // R3: PC holds without its load enable
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_pc |=> $stable(pc));

    // R2: strobes never overlap
    a_r2_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: read strobe lasts one cycle
    a_r2_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R5: write strobe lasts one cycle
    a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R7: exactly one flag set
    a_r7_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);

    // R7: flags hold without their load enable
    a_r7_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_cc |=> $stable(cc));

endmodule

bind shbus_cpu shbus_cpu_chk #(.NSRC(shbus_pkg::BUS_N), .DW(DW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .bus_en (ctl.bus_en),
    .ld_ir  (ctl.ld_ir),
    .ir     (ir),
    .ld_pc  (ctl.ld_pc),
    .pc     (pc),
    .ld_cc  (ctl.ld_cc),
    .cc     (cc)
);

// File: tb/shbus_cpu_tb_top.sv
// Bench for shbus_cpu. A memory model holds a program whose stores expose
// results at the memory port. A driver pushes the expected stores into a
// scoreboard queue, and a monitor pops and compares them as writes appear.
module shbus_cpu_tb_top;

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem [256];
    exp_t        sb_q [$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    int          rd_cnt = 0;
    logic [15:0] rd_log [3];

    always #10ns clk = ~clk;

    shbus_cpu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    // Encoders for the instruction formats named in the requirements.
    function automatic logic [15:0] enc_rr(logic [3:0] op, int dr, int s1, int s2);
        return {op, 3'(dr), 3'(s1), 3'b000, 3'(s2)};
    endfunction
    function automatic logic [15:0] enc_ri(logic [3:0] op, int dr, int s1, int imm);
        return {op, 3'(dr), 3'(s1), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] enc_not(int dr, int sr);
        return {4'b1001, 3'(dr), 3'(sr), 6'b111111};
    endfunction
    function automatic logic [15:0] enc_mem(logic [3:0] op, int r, int b, int off);
        return {op, 3'(r), 3'(b), 6'(off)};
    endfunction
    function automatic logic [15:0] enc_br(logic [2:0] nzp, int off);
        return {4'b0000, nzp, 9'(off)};
    endfunction

    // Program image, word by word.
    function automatic logic [15:0] prog_word(int a);
        case (a)
            0:  return enc_br(3'b010, 1);          // R1: Z after reset -> skip 1
            1:  return enc_br(3'b111, -2);         // trap loop if flags wrong
            2:  return enc_ri(4'b0101, 0, 0, 0);   // R0 = 0
            3:  return enc_ri(4'b0001, 1, 0, 5);   // R1 = 5
            4:  return enc_ri(4'b0001, 2, 0, -3);  // R2 = -3
            5:  return enc_rr(4'b0001, 3, 1, 2);   // R3 = R1 + R2
            6:  return enc_mem(4'b0110, 6, 0, 31); // R6 = mem[31]
            7:  return enc_mem(4'b0111, 3, 6, 0);
            8:  return enc_ri(4'b0101, 4, 2, 6);   // R4 = R2 & 6
            9:  return enc_mem(4'b0111, 4, 6, 1);
            10: return enc_not(5, 3);              // R5 = ~R3
            11: return enc_mem(4'b0111, 5, 6, -1);
            12: return enc_mem(4'b0110, 7, 0, 30); // R7 = mem[30], N
            13: return enc_br(3'b100, 1);          // taken
            14: return enc_mem(4'b0111, 0, 6, 5);  // skipped
            15: return enc_mem(4'b0111, 7, 6, 2);
            16: return enc_ri(4'b0001, 0, 0, 0);   // Z
            17: return enc_br(3'b001, 1);          // not taken
            18: return enc_mem(4'b0111, 1, 6, 3);
            19: return enc_br(3'b010, 1);          // taken
            20: return enc_mem(4'b0111, 2, 6, 6);  // skipped
            21: return 16'hD000;                   // unsupported opcode
            22: return enc_br(3'b101, 1);          // not taken
            23: return enc_mem(4'b0111, 3, 6, 4);
            24: return enc_ri(4'b0001, 1, 1, 10);  // R1 = 15, P
            25: return enc_br(3'b001, 1);          // taken
            26: return enc_mem(4'b0111, 0, 6, 7);  // skipped
            27: return enc_mem(4'b0111, 1, 6, 7);
            28: return enc_br(3'b111, -1);         // park
            30: return 16'h8001;
            31: return 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    // Synchronous memory, one cycle read latency; reloaded during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= prog_word(i);
        end else begin
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    function automatic void check(bit ok, string req, string what,
                                  logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endfunction

    // Driver side of the scoreboard: expected stores for one program run.
    task automatic push_run();
        logic [15:0] r1, r2, r3, r4, r5, r7, r1b;
        r1  = 16'd5;
        r2  = 16'hFFFD;
        r3  = 16'(r1 + r2);
        r4  = r2 & 16'h0006;
        r5  = ~r3;
        r7  = 16'h8001;
        r1b = 16'(r1 + 16'd10);
        sb_q.push_back('{16'h0080, r3,  "R4"});  // register-mode add
        sb_q.push_back('{16'h0081, r4,  "R4"});  // immediate-mode and
        sb_q.push_back('{16'h007F, r5,  "R5"});  // not, negative store offset
        sb_q.push_back('{16'h0082, r7,  "R7"});  // load sets N, BRn taken
        sb_q.push_back('{16'h0083, r1,  "R6"});  // BRp not taken on Z
        sb_q.push_back('{16'h0084, r3,  "R8"});  // no-op kept Z
        sb_q.push_back('{16'h0087, r1b, "R6"});  // BRp taken on P
    endtask

    // Monitor: logs first reads after reset and scores every write.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_cnt = 0;
        end else begin
            if (mem_rd && rd_cnt < 3) begin
                rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end
            if (mem_wr) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected store at", mem_addr, 16'h0000);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(mem_addr == e.addr, e.req, "store address", mem_addr, e.addr);
                    check(mem_wdata == e.data, e.req, "store data", mem_wdata, e.data);
                end
            end
        end
    end

    // Main sequence: two runs, each started by a reset.
    initial begin
        for (int run = 0; run < 2; run++) begin
            @(negedge clk);
            rst_n = 1'b0;
            repeat (4) @(negedge clk);
            check(!mem_rd && !mem_wr, "R1", "strobes in reset",
                  {14'd0, mem_rd, mem_wr}, 16'h0000);
            push_run();
            rst_n = 1'b1;
            for (int i = 0; i < 4000 && sb_q.size() != 0; i++) @(negedge clk);
            check(sb_q.size() == 0, "R5", "stores outstanding",
                  16'(sb_q.size()), 16'h0000);
            repeat (200) @(negedge clk);
            check(rd_log[0] == 16'h0000, "R1", "first fetch address", rd_log[0], 16'h0000);
            check(rd_log[1] == 16'h0002, "R1", "fetch after BRz on reset flags",
                  rd_log[1], 16'h0002);
            check(rd_log[2] == 16'h0003, "R2", "sequential fetch", rd_log[2], 16'h0003);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule